// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Spike-Rejecting Start Detection

This block recovers asynchronous characters from a serial input line. The line is sampled on a clock-enable tick that runs at sixteen times the bit rate. A falling edge on the line is not accepted as a start bit until the line is still low at the middle of that bit. Short pulses on the line therefore never begin a character. After a valid start bit, the block shifts in 5 to 8 data bits, least significant first. If parity is enabled, it then reads an even or odd parity bit, and finally it samples the stop bit.

Each finished character is presented on a byte output with its status flags: parity error, framing error and overrun. A one-cycle valid strobe marks the character, and a level flag stays set until the host acknowledges the read. A character made only of zeros, with a low stop bit, is treated as a line break. A break is not delivered as a character. It raises a pulse when it is detected and a second pulse when the line returns high. After a framing error, the block waits an extra half bit before it looks for a new start bit, so that the bad stop bit is not taken as the next start.

Top module: `async_rx`

## Requirements
- R1: `cfg_len` sets the data length: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8. Data bits arrive least significant bit first, after one low start bit, and end with one stop bit.
- R2: A character shorter than 8 bits appears in the low bits of `rx_data`, and the unused upper bits read zero.
- R3: When `cfg_par_en` is 1, one parity bit follows the data bits. `cfg_par_odd` = 0 means the data bits and the parity bit together hold an even number of ones, and 1 means an odd number. `err_parity` is set for a character that breaks this rule. When parity is disabled, no parity bit is expected and `err_parity` is 0.
- R4: A low pulse on `rxd` that ends before half a bit time (8 ticks) has passed starts no character and produces no output.
- R5: A character whose stop bit samples low, and which is not a break, is delivered with `err_frame` = 1 and its data bits intact.
- R6: After a framing error, the search for a start bit stays suspended for half a bit time (8 ticks) after the stop-bit sample. A low level that ends within 16 ticks of that sample therefore yields no second character.
- R7: `err_overrun` is 1 on a delivered character when the previous character had not yet been read with `rd`.
- R8: A character with all data bits zero, a zero parity bit (if enabled) and a low stop bit raises `brk_start` for one cycle. It is not delivered: no `rx_valid` pulse.
- R9: While a break lasts, no characters are delivered. The first high level on the line afterwards raises `brk_end` for one cycle, and normal reception then resumes.
- R10: `rx_valid` is a one-cycle strobe. `rx_full` is set with it and stays set until `rd` is pulsed. Reset clears `rx_valid`, `rx_full`, `brk_start` and `brk_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sampling enable at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idles high |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd | input | 1 | Host read acknowledge, clears `rx_full` |
| rx_data | output | 8 | Received character, right-justified |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| rx_full | output | 1 | An unread character is held |
| err_parity | output | 1 | Parity error for the held character |
| err_frame | output | 1 | Framing error for the held character |
| err_overrun | output | 1 | Held character overwrote an unread one |
| brk_start | output | 1 | Pulse when a break is detected |
| brk_end | output | 1 | Pulse when the line leaves a break |

## Verification
Random characters of every length, with parity off, even or odd, and with some parity bits deliberately flipped, show that the bit order, right-justification and parity check all hold across the configuration space. Directed patterns cover the rest. A short low spike is used to tell real start validation from plain edge triggering. A low stop bit that stays low past its sample separates the half-bit recovery delay from an immediate restart. Two unread characters in a row show the overrun flag, and a long all-zero stretch shows that a break is reported at entry and at exit, and that no character is delivered during it.

// File: rtl/async_rx.sv
module async_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       rd,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_full,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun,
  output logic       brk_start,
  output logic       brk_end
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] HALF_M1 = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP, FDLY, BRK} st_t;
  st_t st;

  logic [1:0]    sync;
  logic          rx;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    sr;
  logic          pbit;
  logic [7:0]    just;
  logic          perr, is_brk;

  assign rx     = sync[1];
  assign just   = sr >> (2'd3 - cfg_len);
  assign perr   = cfg_par_en && ((^just ^ pbit) != cfg_par_odd);
  assign is_brk = (just == 8'd0) && !(cfg_par_en && pbit) && !rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= 2'b11;
      st <= IDLE;
      cnt <= '0;
      bidx <= '0;
      sr <= '0;
      pbit <= 1'b0;
      rx_data <= '0;
      rx_valid <= 1'b0;
      rx_full <= 1'b0;
      err_parity <= 1'b0;
      err_frame <= 1'b0;
      err_overrun <= 1'b0;
      brk_start <= 1'b0;
      brk_end <= 1'b0;
    end else begin
      sync <= {sync[0], rxd};
      rx_valid <= 1'b0;
      brk_start <= 1'b0;
      brk_end <= 1'b0;
      if (rd) rx_full <= 1'b0;
      if (tick) begin
        case (st)
          IDLE: if (!rx) begin
            st <= START;
            cnt <= '0;
          end
          START: begin
            cnt <= cnt + 1'b1;
            if (cnt == HALF_M1) begin
              cnt <= '0;
              bidx <= '0;
              st <= rx ? IDLE : DATA;
            end
          end
          DATA: begin
            cnt <= cnt + 1'b1;
            if (cnt == FULL_M1) begin
              sr <= {rx, sr[7:1]};
              bidx <= bidx + 1'b1;
              if (bidx == 3'd4 + {1'b0, cfg_len}) st <= cfg_par_en ? PAR : STOP;
            end
          end
          PAR: begin
            cnt <= cnt + 1'b1;
            if (cnt == FULL_M1) begin
              pbit <= rx;
              st <= STOP;
            end
          end
          STOP: begin
            cnt <= cnt + 1'b1;
            if (cnt == FULL_M1) begin
              if (is_brk) begin
                brk_start <= 1'b1;
                st <= BRK;
              end else begin
                rx_data <= just;
                rx_valid <= 1'b1;
                rx_full <= 1'b1;
                err_parity <= perr;
                err_frame <= !rx;
                err_overrun <= rx_full && !rd;
                cnt <= '0;
                st <= rx ? IDLE : FDLY;
              end
            end
          end
          FDLY: begin
            cnt <= cnt + 1'b1;
            if (cnt == HALF_M1) st <= IDLE;
          end
          BRK: if (rx) begin
            brk_end <= 1'b1;
            st <= IDLE;
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  // R8
  brk_no_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |-> !rx_valid);

  // R9
  brk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |=> !brk_end);

  // R10
  valid_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10
  valid_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_full);

  // R2
  justify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_len == 2'd0) |-> (rx_data[7:5] == 3'd0));

  // R9
  brk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BRK) |-> !rx_valid);
endmodule

// File: tb/async_rx_test.sv
module async_rx_test;
  localparam int TDIV = 4;
  localparam int TPB  = 16;
  localparam int BITC = TDIV * TPB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick, rxd = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, rd = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic [7:0] rx_data;
  logic rx_valid, rx_full, err_parity, err_frame, err_overrun, brk_start, brk_end;

  int checks = 0, fails = 0, ncyc = 0, tdiv_cnt = 0;
  int nval = 0, nbs = 0, nbe = 0;
  logic [7:0] c_data;
  logic c_pe, c_fe, c_ov;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    tdiv_cnt <= (tdiv_cnt == TDIV-1) ? 0 : tdiv_cnt + 1;
  end
  assign tick = (tdiv_cnt == TDIV-1);

  async_rx uut (.*);

  always @(negedge clk) begin
    ncyc++;
    if (rx_valid) begin
      nval++; c_data = rx_data; c_pe = err_parity; c_fe = err_frame; c_ov = err_overrun;
    end
    if (brk_start) nbs++;
    if (brk_end) nbe++;
    if (ncyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", ncyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_par(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic bit_time(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input logic pen,
                      input logic pval, input logic stopv);
    bit_time(1'b0, BITC);
    for (int i = 0; i < nb; i++) bit_time(d[i], BITC);
    if (pen) bit_time(pval, BITC);
    bit_time(stopv, BITC);
    bit_time(1'b1, 2*BITC);
  endtask

  task automatic do_rd();
    rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
  endtask

  initial begin
    int v0;
    logic [7:0] d, m;
    int nb;
    logic pen, podd, bad, pv;
    void'($urandom(32'h5eed_1234));
    repeat (6) @(negedge clk);
    // R10 reset state
    chk(!rx_valid && !rx_full && !brk_start && !brk_end, "R10 reset", {rx_valid, rx_full}, 0);
    rst_n = 1'b1;
    bit_time(1'b1, 2*BITC);

    // R1 R2 R3 random characters
    for (int k = 0; k < 30; k++) begin
      cfg_len = 2'($urandom_range(0, 3));
      nb = 5 + cfg_len;
      pen = 1'($urandom_range(0, 1));
      podd = 1'($urandom_range(0, 1));
      bad = pen && ($urandom_range(0, 3) == 0);
      m = 8'((1 << nb) - 1);
      d = 8'($urandom) & m;
      if (d == 0) d = 8'h01;
      cfg_par_en = pen; cfg_par_odd = podd;
      pv = exp_par(d, podd) ^ bad;
      v0 = nval;
      send(d, nb, pen, pv, 1'b1);
      chk(nval == v0 + 1, "R1 count", nval, v0 + 1);
      chk(c_data == d, "R1 R2 data", c_data, d);
      chk(c_pe == bad, "R3 parity flag", c_pe, bad);
      chk(!c_fe && !c_ov, "R5 R7 no error", {c_fe, c_ov}, 0);
      do_rd();
      chk(!rx_full, "R10 read clears full", rx_full, 0);
    end

    cfg_len = 2'd3; cfg_par_en = 1'b0;
    // R4 spike
    v0 = nval;
    bit_time(1'b0, 3*TDIV);
    bit_time(1'b1, 3*BITC);
    chk(nval == v0, "R4 spike rejected", nval, v0);
    chk(!rx_full, "R4 nothing held", rx_full, 0);

    // R5 R6 framing error, line low 12 ticks past stop sample
    v0 = nval;
    bit_time(1'b0, BITC);
    for (int i = 0; i < 8; i++) bit_time(i[0], BITC);
    bit_time(1'b0, BITC + 4*TDIV);
    bit_time(1'b1, 4*BITC);
    chk(nval == v0 + 1, "R6 single char after frame error", nval, v0 + 1);
    chk(c_fe, "R5 framing flag", c_fe, 1);
    chk(c_data == 8'hAA, "R5 data kept", c_data, 8'hAA);
    do_rd();

    // R7 overrun
    send(8'h3C, 8, 1'b0, 1'b0, 1'b1);
    chk(!c_ov, "R7 first no overrun", c_ov, 0);
    send(8'hC3, 8, 1'b0, 1'b0, 1'b1);
    chk(c_ov, "R7 overrun flagged", c_ov, 1);
    chk(c_data == 8'hC3, "R7 newest data", c_data, 8'hC3);
    do_rd();
    send(8'h5A, 8, 1'b0, 1'b0, 1'b1);
    chk(!c_ov, "R7 overrun cleared", c_ov, 0);
    do_rd();

    // R8 R9 break, 6-bit with even parity
    cfg_len = 2'd1; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    v0 = nval;
    bit_time(1'b0, 14*BITC);
    chk(nbs == 1, "R8 break start", nbs, 1);
    chk(nbe == 0, "R9 no early end", nbe, 0);
    chk(nval == v0, "R8 R9 no char in break", nval, v0);
    bit_time(1'b1, 2*BITC);
    chk(nbe == 1, "R9 break end", nbe, 1);
    send(8'h2D, 6, 1'b1, exp_par(8'h2D, 1'b0), 1'b1);
    chk(nval == v0 + 1 && c_data == 8'h2D, "R9 resume", c_data, 8'h2D);
    chk(!c_pe, "R3 parity after break", c_pe, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule